// File: doc/BRIEF.md
# Master-ID Address Access Filter

This block sits between a shared bus layer and the slaves behind it and decides, for every transfer, whether the master that issued it may reach the target. Each request carries the ID of the issuing master. The trusted master (ID 1) may select any slave. The untrusted master (ID 0) may only reach addresses that fall inside one of a set of enabled windows. It is also refused every slave that is marked secure, even when a window covers that slave. The crypto accelerator is one such secure slave.

The windows are programmed through a separate configuration port during early boot, before the untrusted master leaves reset. Only the trusted master may write them. A lock bit freezes the whole window set until the next reset.

A refused transfer selects no slave and is answered with a two-cycle error response. The first refused transfer after reset is recorded: its master ID and address are held in a sticky violation record.

Top module: `mid_access_filter`

## Requirements
- R1: A request accepted from master ID 1 asserts exactly the slave select given by the top `log2(NSLV)` address bits, in the same cycle, whatever the window and lock state.
- R2: A request from master ID 0 is allowed only if, for some enabled window, `(addr ^ base) & mask` is zero. An allowed request selects the decoded slave in the same cycle.
- R3: A request from master ID 0 to a slave whose bit in `SECURE_MAP` is 1 is refused, even when an enabled window matches it.
- R4: An accepted, refused request asserts no slave select. In the cycle after it, `m_ready`=0 and `m_err`=1. In the next cycle, `m_ready`=1 and `m_err`=1. After that, `m_err` returns to 0.
- R5: A configuration write with `cfg_id`=0 changes no window. In the following cycle it is answered with `cfg_err`=1. A write with `cfg_id`=1 while unlocked gives `cfg_err`=0.
- R6: A trusted write with `cfg_field`=3 and `cfg_wdata[0]`=1 sets the lock. After that, every configuration write is ignored and answered with `cfg_err`=1 until reset. The meaning of `cfg_field` is: 0 = base, 1 = mask, 2 = enable (taken from `cfg_wdata[0]`), 3 = lock.
- R7: The first refused request after reset sets `viol_flag` and loads `viol_id` and `viol_addr`. Later refusals leave all three unchanged.
- R8: After reset, all windows are disabled and the lock is clear. `viol_flag`, `m_err`, `cfg_err` and every slave select are 0, `m_ready` is 1, and every ID 0 request is refused.
- R9: A window whose enable bit is 0 never allows a request, whatever its base and mask hold.
- R10: While `m_ready` is 0, no request is accepted and no slave select is asserted. A request held through that cycle is decided in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | 1 | Transfer request present |
| m_id | input | 1 | Issuing master: 1 = trusted, 0 = untrusted |
| m_addr | input | AW | Transfer address |
| m_ready | output | 1 | Filter can accept a request this cycle |
| m_err | output | 1 | Error response in progress |
| s_sel | output | NSLV | One-hot slave select |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_id | input | 1 | Master ID of the configuration write |
| cfg_idx | input | RW | Window index |
| cfg_field | input | 2 | Field select: 0 base, 1 mask, 2 enable, 3 lock |
| cfg_wdata | input | AW | Configuration write data |
| cfg_err | output | 1 | Previous configuration write was refused |
| viol_flag | output | 1 | A refusal has been recorded |
| viol_id | output | 1 | Master ID of the recorded refusal |
| viol_addr | output | AW | Address of the recorded refusal |

## Verification
The bench builds the filter with `AW`=16, `NSLV`=4, `NREG`=4 and `SECURE_MAP`=4'b1000. With these values the slave index is the top two address bits, so every slave, including the secure one, can be reached with short, readable addresses. Four windows are enough to give one window that covers the secure slave, one that is disabled, and two narrow windows whose edges can be probed one address inside and one address outside. The bench also holds a trusted request through the stalled error cycle, to show that the request is decided only once `m_ready` returns.

// File: rtl/mid_access_filter.sv
module mid_access_filter #(
  parameter int AW = 32,
  parameter int NREG = 4,
  parameter int NSLV = 8,
  parameter logic [NSLV-1:0] SECURE_MAP = 8'hC0,
  localparam int SW = $clog2(NSLV),
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_valid,
  input  logic            m_id,
  input  logic [AW-1:0]   m_addr,
  output logic            m_ready,
  output logic            m_err,
  output logic [NSLV-1:0] s_sel,
  input  logic            cfg_wr,
  input  logic            cfg_id,
  input  logic [RW-1:0]   cfg_idx,
  input  logic [1:0]      cfg_field,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            cfg_err,
  output logic            viol_flag,
  output logic            viol_id,
  output logic [AW-1:0]   viol_addr
);

  typedef enum logic [1:0] {RSP_IDLE, RSP_ERR1, RSP_ERR2} rsp_t;

  rsp_t            rsp_q;
  logic [AW-1:0]   base_q [NREG];
  logic [AW-1:0]   mask_q [NREG];
  logic [NREG-1:0] en_q;
  logic            lock_q;
  logic [NREG-1:0] hit;
  logic [SW-1:0]   slv_idx;
  logic            is_secure, allowed, accept, deny, cfg_ok;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign hit[g] = en_q[g] && (((m_addr ^ base_q[g]) & mask_q[g]) == '0);
  end

  assign slv_idx   = m_addr[AW-1 -: SW];
  assign is_secure = SECURE_MAP[slv_idx];
  assign allowed   = m_id || ((|hit) && !is_secure);
  assign m_ready   = (rsp_q != RSP_ERR1);
  assign m_err     = (rsp_q != RSP_IDLE);
  assign accept    = m_valid && m_ready;
  assign deny      = accept && !allowed;
  assign s_sel     = (accept && allowed) ? (NSLV'(1) << slv_idx) : '0;
  assign cfg_ok    = cfg_wr && cfg_id && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= RSP_IDLE;
    end else if (deny) begin
      rsp_q <= RSP_ERR1;
    end else if (rsp_q == RSP_ERR1) begin
      rsp_q <= RSP_ERR2;
    end else begin
      rsp_q <= RSP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      lock_q  <= 1'b0;
      cfg_err <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      cfg_err <= cfg_wr && !cfg_ok;
      if (cfg_ok) begin
        if (cfg_field == 2'd3) begin
          lock_q <= cfg_wdata[0];
        end
        for (int i = 0; i < NREG; i++) begin
          if (cfg_idx == RW'(i)) begin
            case (cfg_field)
              2'd0:    base_q[i] <= cfg_wdata;
              2'd1:    mask_q[i] <= cfg_wdata;
              2'd2:    en_q[i]   <= cfg_wdata[0];
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_flag <= 1'b0;
      viol_id   <= 1'b0;
      viol_addr <= '0;
    end else if (deny && !viol_flag) begin
      viol_flag <= 1'b1;
      viol_id   <= m_id;
      viol_addr <= m_addr;
    end
  end

endmodule

module mid_access_filter_chk #(
  parameter int AW = 32,
  parameter int NSLV = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            m_valid,
  input logic            m_id,
  input logic            m_ready,
  input logic            m_err,
  input logic [NSLV-1:0] s_sel,
  input logic            cfg_wr,
  input logic            cfg_id,
  input logic            cfg_err,
  input logic            viol_flag,
  input logic            viol_id,
  input logic [AW-1:0]   viol_addr
);

  // R1
  trusted_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_id) |-> ($countones(s_sel) == 1));

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sel));

  // R4
  deny_err1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && (s_sel == '0)) |=> (!m_ready && m_err));

  // R4
  err2_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ready |=> (m_ready && m_err));

  // R10
  stall_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ready |-> (s_sel == '0));

  // R5
  cfg_untrusted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_id) |=> cfg_err);

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |=> (viol_flag && $stable(viol_addr) && $stable(viol_id)));

endmodule

bind mid_access_filter mid_access_filter_chk #(.AW(AW), .NSLV(NSLV)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_id(m_id),
  .m_ready(m_ready), .m_err(m_err), .s_sel(s_sel), .cfg_wr(cfg_wr),
  .cfg_id(cfg_id), .cfg_err(cfg_err), .viol_flag(viol_flag),
  .viol_id(viol_id), .viol_addr(viol_addr)
);

// File: tb/tb_mid_access_filter.sv
module tb_mid_access_filter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NSLV = 4;
  localparam int NREG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_valid = 1'b0, m_id = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic m_ready, m_err, cfg_err, viol_flag, viol_id;
  logic [NSLV-1:0] s_sel;
  logic cfg_wr = 1'b0, cfg_id = 1'b0;
  logic [1:0] cfg_idx = '0, cfg_field = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] viol_addr;
  int n_run = 0, n_fail = 0;

  mid_access_filter #(.AW(AW), .NREG(NREG), .NSLV(NSLV), .SECURE_MAP(4'b1000)) dut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_id(m_id), .m_addr(m_addr),
    .m_ready(m_ready), .m_err(m_err), .s_sel(s_sel), .cfg_wr(cfg_wr),
    .cfg_id(cfg_id), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .viol_flag(viol_flag),
    .viol_id(viol_id), .viol_addr(viol_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {id, addr[15:0], ok, idx[1:0]}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 16'h0000, 1'b1, 2'd0},
    {1'b1, 16'hC123, 1'b1, 2'd3},
    {1'b0, 16'h4ABC, 1'b1, 2'd1},
    {1'b0, 16'h4FFF, 1'b1, 2'd1},
    {1'b0, 16'h5000, 1'b0, 2'd1},
    {1'b0, 16'hC150, 1'b0, 2'd3},
    {1'b0, 16'h8004, 1'b0, 2'd2},
    {1'b0, 16'h0015, 1'b1, 2'd0},
    {1'b0, 16'h0020, 1'b0, 2'd0},
    {1'b1, 16'h8004, 1'b1, 2'd2}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic id, input logic [1:0] idx, input logic [1:0] fld,
                     input logic [AW-1:0] d, input logic exp_err, input string req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_id = id; cfg_idx = idx; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(cfg_err == exp_err, req, cfg_err, exp_err);
  endtask

  task automatic access(input logic id, input logic [AW-1:0] a, input logic ok,
                        input logic [1:0] idx, input string req);
    logic [NSLV-1:0] exp_sel;
    exp_sel = ok ? (NSLV'(1) << idx) : '0;
    @(negedge clk);
    m_valid = 1'b1; m_id = id; m_addr = a;
    #1;
    check(s_sel == exp_sel, req, s_sel, exp_sel);
    @(negedge clk);
    m_valid = 1'b0;
    if (!ok) begin
      check(!m_ready && m_err, {req, " err1"}, {m_ready, m_err}, 2'b01);
      @(negedge clk);
      check(m_ready && m_err, {req, " err2"}, {m_ready, m_err}, 2'b11);
      @(negedge clk);
      check(!m_err, {req, " err end"}, m_err, 0);
    end else begin
      check(!m_err && m_ready, {req, " no err"}, {m_ready, m_err}, 2'b10);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(m_ready && !m_err && !cfg_err && !viol_flag && s_sel == '0, "R8 reset",
          {m_ready, m_err, cfg_err, viol_flag}, 4'b1000);
    access(1'b0, 16'h4000, 1'b0, 2'd1, "R8 untrusted denied after reset");
    // R7 first violation recorded
    check(viol_flag && !viol_id && viol_addr == 16'h4000, "R7 record",
          viol_addr, 16'h4000);

    cfg(1'b1, 2'd0, 2'd0, 16'h4000, 1'b0, "R5 trusted base0");
    cfg(1'b1, 2'd0, 2'd1, 16'hF000, 1'b0, "R5 trusted mask0");
    cfg(1'b1, 2'd0, 2'd2, 16'h0001, 1'b0, "R5 trusted en0");
    cfg(1'b1, 2'd1, 2'd0, 16'hC100, 1'b0, "R5 base1");
    cfg(1'b1, 2'd1, 2'd1, 16'hFF00, 1'b0, "R5 mask1");
    cfg(1'b1, 2'd1, 2'd2, 16'h0001, 1'b0, "R5 en1");
    cfg(1'b1, 2'd2, 2'd0, 16'h8000, 1'b0, "R9 base2");
    cfg(1'b1, 2'd2, 2'd1, 16'hC000, 1'b0, "R9 mask2");
    cfg(1'b1, 2'd3, 2'd0, 16'h0010, 1'b0, "R2 base3");
    cfg(1'b1, 2'd3, 2'd1, 16'hFFF0, 1'b0, "R2 mask3");
    cfg(1'b1, 2'd3, 2'd2, 16'h0001, 1'b0, "R2 en3");

    // R1 R2 R3 R9 table
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][19], VEC[i][18:3], VEC[i][2], VEC[i][1:0],
             $sformatf("R1/R2/R3/R9 vec%0d", i));
    end
    // R7 later refusals do not overwrite
    check(viol_flag && !viol_id && viol_addr == 16'h4000, "R7 sticky",
          viol_addr, 16'h4000);

    // R5 untrusted cannot enable window 2
    cfg(1'b0, 2'd2, 2'd2, 16'h0001, 1'b1, "R5 untrusted write err");
    access(1'b0, 16'h8004, 1'b0, 2'd2, "R5 window2 still off");

    // R10 request held through stall cycle
    @(negedge clk);
    m_valid = 1'b1; m_id = 1'b0; m_addr = 16'h5000;
    @(negedge clk);
    m_id = 1'b1; m_addr = 16'h0000;
    #1;
    check(!m_ready && s_sel == '0, "R10 stall no sel", s_sel, 0);
    @(negedge clk);
    #1;
    check(m_ready && s_sel == 4'b0001, "R10 held request decided", s_sel, 4'b0001);
    @(negedge clk);
    m_valid = 1'b0;
    @(negedge clk);

    // R6 lock
    cfg(1'b1, 2'd0, 2'd3, 16'h0001, 1'b0, "R6 set lock");
    cfg(1'b1, 2'd0, 2'd2, 16'h0000, 1'b1, "R6 write after lock err");
    access(1'b0, 16'h4ABC, 1'b1, 2'd1, "R6 window0 still on");
    cfg(1'b1, 2'd2, 2'd2, 16'h0001, 1'b1, "R6 enable after lock err");
    access(1'b0, 16'h8004, 1'b0, 2'd2, "R6 window2 still off");
    access(1'b1, 16'hC000, 1'b1, 2'd3, "R1 trusted under lock");

    // R8 reset clears lock, windows and record
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!viol_flag && !m_err && m_ready, "R8 second reset", viol_flag, 0);
    access(1'b0, 16'h4ABC, 1'b0, 2'd1, "R8 windows cleared");
    cfg(1'b1, 2'd0, 2'd2, 16'h0001, 1'b0, "R8 lock cleared");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule